// File: doc/BRIEF.md
# Strap-Latched Frequency Select Unit

This block sits beside a clock synthesizer whose frequency-select pins are shared with clock outputs. While power-on reset is in progress, the shared pads are inputs carrying board-strapped levels. The block times a fixed power-on sequence after `rst_ni` releases. On the last cycle of that sequence it stores five frequency-select levels and one 24/48 MHz select level. From the next cycle on it enables the pad drivers, so the pins carry clocks.

A control byte chooses where the frequency code comes from. With the select bit clear, the code is the one captured from the straps. With it set, the code comes from five bits spread over the byte. The same byte carries a spread-spectrum enable and a request to tristate all outputs. Three read-only status bytes report the captured levels in inverted form, so firmware can see how the board was strapped. The captured levels stay fixed until the next power-on reset.

Top module: `strap_fsel_unit`

## Requirements
- R1: After `rst_ni` rises, `pad_oe_o` stays 0 through the first RESET_CYCLES-1 rising edges. It becomes 1 after rising edge RESET_CYCLES and stays 1 until the next reset.
- R2: The latched levels equal `strap_fs_i`/`strap_sel_i` as sampled at rising edge RESET_CYCLES after reset release. Strap values before that edge, and all values after it, have no effect on the latch.
- R3: The control byte (address 0) reads 0 after reset. While its bit 3 is 0, `fs_code_o` equals the latched strap code.
- R4: While control bit 3 is 1, `fs_code_o[4:0]` equals the control bits {2, 7, 6, 5, 4}. That is, bit 2 gives code bit 4 and bits 7..4 give code bits 3..0.
- R5: `ss_en_o` follows control bit 1 and `tristate_o` follows control bit 0.
- R6: `sel24_o` equals the latched 24/48 select level, where 1 requests 24 MHz and 0 requests 48 MHz.
- R7: Reads with `cfg_addr_i` set to 1, 2 or 3 return status bytes whose bits 5..0 are 0:
  - Address 1: bit 7 = inverted FS0, bit 6 = inverted FS1.
  - Address 2: bit 7 = inverted FS2, bit 6 = inverted FS3.
  - Address 3: bit 7 = inverted FS4, bit 6 = inverted 24/48 select.
  - Addresses 4 to 7 read 0.
- R8: A write to any address other than 0 changes no register, no status byte and no output.
- R9: A write issued while `pad_oe_o` is 0 is ignored.
- R10: A write to address 0 with `cfg_we_i` high at a rising edge updates the control byte at that edge. The affected outputs reflect it right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| strap_fs_i | input | 5 | Strapped frequency-select levels seen on the shared pads |
| strap_sel_i | input | 1 | Strapped 24/48 MHz select level |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register byte address for read and write |
| cfg_wdata_i | input | 8 | Write data |
| cfg_rdata_o | output | 8 | Read data for `cfg_addr_i` |
| pad_oe_o | output | 1 | Output enable for the shared pads; high once the straps are captured |
| fs_code_o | output | 5 | Active frequency code to the synthesizer |
| ss_en_o | output | 1 | Spread-spectrum enable |
| tristate_o | output | 1 | Request to tristate all clock outputs |
| sel24_o | output | 1 | 1 selects 24 MHz, 0 selects 48 MHz |

## Verification
The assertions check several properties on every cycle:
- the pad enable never drops once raised;
- the strap latch holds steady once capture is done;
- the control byte stays at reset value until the pads are enabled;
- writes to status addresses leave the control byte unchanged;
- the frequency code moves only when its source changes.

Only the bench scenarios can show the following:
- that capture lands exactly on the last sequence cycle, with different strap values before and after that edge;
- that the bit shuffle from control bits to frequency code is correct;
- that the inverted status formatting is right for two distinct strap patterns.

// File: rtl/strap_fsel_pkg.sv
package strap_fsel_pkg;
  localparam int NUM_FS  = 5;
  localparam int NUM_LVL = NUM_FS + 1;           // fs levels plus 24/48 select
  localparam int NUM_STAT = (NUM_LVL + 1) / 2;   // two inverted levels per status byte

  // control byte, msb first
  typedef struct packed {
    logic fs3;
    logic fs2;
    logic fs1;
    logic fs0;
    logic sw_sel;
    logic fs4;
    logic ss_en;
    logic tri_all;
  } ctrl_t;

  function automatic logic [NUM_FS-1:0] sw_code(ctrl_t c);
    return {c.fs4, c.fs3, c.fs2, c.fs1, c.fs0};
  endfunction
endpackage

// File: rtl/por_seq.sv
module por_seq #(
  parameter int RESET_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic cap_o,
  output logic done_o
);
  localparam int CNT_W = (RESET_CYCLES > 2) ? $clog2(RESET_CYCLES) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  assign cap_o  = !done_q && (cnt_q == CNT_W'(RESET_CYCLES - 1));
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (cap_o) done_q <= 1'b1;
      else       cnt_q  <= cnt_q + 1'b1;
    end
  end

  assert_oe_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> done_q);
endmodule

// File: rtl/strap_latch.sv
module strap_latch #(
  parameter int WIDTH = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic             done_i,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    q_o[i] <= 1'b0;
      else if (cap_i) q_o[i] <= lvl_i[i];
    end
  end

  assert_latch_frozen_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> $stable(q_o));
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import strap_fsel_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               done_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NUM_LVL-1:0] lvl_i,
  output ctrl_t              ctrl_o,
  output logic [DATA_W-1:0]  rdata_o
);
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] stat_byte [NUM_STAT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                     ctrl_q <= '0;
    else if (done_i && we_i && addr_i == '0)         ctrl_q <= ctrl_t'(wdata_i[7:0]);
  end
  assign ctrl_o = ctrl_q;

  // inverted captured levels in the two top bits of each status byte
  for (genvar k = 0; k < NUM_STAT; k++) begin : g_stat
    always_comb begin
      stat_byte[k] = '0;
      stat_byte[k][DATA_W-1] = ~lvl_i[2*k];
      if (2*k + 1 < NUM_LVL) stat_byte[k][DATA_W-2] = ~lvl_i[2*k+1];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == '0) rdata_o = DATA_W'(ctrl_q);
    for (int k = 0; k < NUM_STAT; k++)
      if (addr_i == ADDR_W'(k + 1)) rdata_o = stat_byte[k];
  end

  assert_early_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |-> ctrl_q == '0);
  assert_status_ro_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i != '0) |=> $stable(ctrl_q));
endmodule

// File: rtl/fsel_mux.sv
module fsel_mux
  import strap_fsel_pkg::*;
(
  input  ctrl_t             ctrl_i,
  input  logic [NUM_FS-1:0] hw_code_i,
  output logic [NUM_FS-1:0] fs_code_o,
  output logic              ss_en_o,
  output logic              tri_o
);
  assign fs_code_o = ctrl_i.sw_sel ? sw_code(ctrl_i) : hw_code_i;
  assign ss_en_o   = ctrl_i.ss_en;
  assign tri_o     = ctrl_i.tri_all;
endmodule

// File: rtl/strap_fsel_unit.sv
module strap_fsel_unit
  import strap_fsel_pkg::*;
#(
  parameter int RESET_CYCLES = 16,
  parameter int ADDR_W       = 3,
  parameter int DATA_W       = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_FS-1:0] strap_fs_i,
  input  logic              strap_sel_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  output logic              pad_oe_o,
  output logic [NUM_FS-1:0] fs_code_o,
  output logic              ss_en_o,
  output logic              tristate_o,
  output logic              sel24_o
);
  logic               cap, done;
  logic [NUM_LVL-1:0] lvl_q;
  ctrl_t              ctrl;

  por_seq #(.RESET_CYCLES(RESET_CYCLES)) i_por_seq (
    .clk_i (clk_i), .rst_ni(rst_ni), .cap_o(cap), .done_o(done)
  );

  strap_latch #(.WIDTH(NUM_LVL)) i_strap_latch (
    .clk_i (clk_i), .rst_ni(rst_ni), .cap_i(cap), .done_i(done),
    .lvl_i ({strap_sel_i, strap_fs_i}), .q_o(lvl_q)
  );

  cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_cfg_regs (
    .clk_i (clk_i), .rst_ni(rst_ni), .done_i(done), .we_i(cfg_we_i),
    .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i), .lvl_i(lvl_q),
    .ctrl_o(ctrl), .rdata_o(cfg_rdata_o)
  );

  fsel_mux i_fsel_mux (
    .ctrl_i(ctrl), .hw_code_i(lvl_q[NUM_FS-1:0]),
    .fs_code_o(fs_code_o), .ss_en_o(ss_en_o), .tri_o(tristate_o)
  );

  assign pad_oe_o = done;
  assign sel24_o  = lvl_q[NUM_LVL-1];

  assert_code_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(ctrl) && $stable(lvl_q)) |-> $stable(fs_code_o));
  assert_pads_after_cap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pad_oe_o) |-> $past(cap));
endmodule

// File: tb/test_strap_fsel_unit.sv
module test_strap_fsel_unit;
  localparam int N = 16;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] strap_fs_i = '0;
  logic       strap_sel_i = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [2:0] cfg_addr_i = '0;
  logic [7:0] cfg_wdata_i = '0;
  logic [7:0] cfg_rdata_o;
  logic       pad_oe_o, ss_en_o, tristate_o, sel24_o;
  logic [4:0] fs_code_o;

  int checks = 0, fails = 0;

  always #10 clk_i = ~clk_i;

  strap_fsel_unit #(.RESET_CYCLES(N)) i_strap_fsel_unit (.*);

  // {wdata, exp_code, exp_ss, exp_tri} with straps fs=10110
  localparam logic [14:0] VEC [8] = '{
    {8'h00, 5'b10110, 1'b0, 1'b0},
    {8'h08, 5'b00000, 1'b0, 1'b0},
    {8'h0C, 5'b10000, 1'b0, 1'b0},
    {8'hF8, 5'b01111, 1'b0, 1'b0},
    {8'h1A, 5'b00001, 1'b1, 1'b0},
    {8'hA9, 5'b01010, 1'b0, 1'b1},
    {8'hF7, 5'b10110, 1'b1, 1'b1},
    {8'h46, 5'b10110, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] stat_exp(input int a, input logic [4:0] fs, input logic sel);
    logic [5:0] l = {sel, fs};
    if (a >= 1 && a <= 3) return {~l[2*(a-1)], ~l[2*(a-1)+1], 6'b0};
    return 8'h00;
  endfunction

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk_i);
    cfg_addr_i = a;
    #1 d = cfg_rdata_o;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0; cfg_addr_i = '0;
  endtask

  // early values held until just before the capture edge, then final values
  task automatic por(input logic [4:0] early_fs, input logic early_sel,
                     input logic [4:0] fs, input logic sel, input bit early_write);
    @(negedge clk_i);
    rst_ni = 1'b0;
    strap_fs_i = early_fs; strap_sel_i = early_sel;
    @(negedge clk_i);
    chk("R1 oe in reset", {7'b0, pad_oe_o}, 8'h00);
    chk("R3 code in reset", {3'b0, fs_code_o}, 8'h00);
    rst_ni = 1'b1;
    if (early_write) begin
      cfg_we_i = 1'b1; cfg_addr_i = '0; cfg_wdata_i = 8'hFF;
    end
    repeat (N - 1) @(negedge clk_i);
    cfg_we_i = 1'b0;
    chk("R1 oe before last edge", {7'b0, pad_oe_o}, 8'h00);
    strap_fs_i = fs; strap_sel_i = sel;
    @(negedge clk_i);
    chk("R1 oe after capture", {7'b0, pad_oe_o}, 8'h01);
    strap_fs_i = ~fs; strap_sel_i = ~sel;  // post-capture changes must be ignored
  endtask

  logic [7:0] d;

  initial begin
    // first power-on: straps 10110, select 1 (24 MHz)
    por(5'b01001, 1'b0, 5'b10110, 1'b1, 1'b0);
    repeat (3) @(negedge clk_i);
    chk("R2 hw code", {3'b0, fs_code_o}, 8'h16);
    chk("R6 sel24", {7'b0, sel24_o}, 8'h01);
    rd(3'd0, d); chk("R3 ctrl reset", d, 8'h00);
    for (int a = 1; a < 8; a++) begin
      rd(3'(a), d); chk("R7 status", d, stat_exp(a, 5'b10110, 1'b1));
    end

    for (int i = 0; i < 8; i++) begin
      wr(3'd0, VEC[i][14:7]);
      #1;
      chk("R4 code", {3'b0, fs_code_o}, {3'b0, VEC[i][6:2]});
      chk("R5 ss", {7'b0, ss_en_o}, {7'b0, VEC[i][1]});
      chk("R5 tri", {7'b0, tristate_o}, {7'b0, VEC[i][0]});
      rd(3'd0, d); chk("R10 readback", d, VEC[i][14:7]);
    end

    // R10: update visible right after the write edge
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = '0; cfg_wdata_i = 8'h5B;
    @(posedge clk_i); #1;
    chk("R10 same-edge", {3'b0, fs_code_o}, 8'h05);
    @(negedge clk_i); cfg_we_i = 1'b0;

    // R8: writes to status addresses ignored
    for (int a = 1; a < 8; a++) wr(3'(a), 8'hFF);
    #1;
    chk("R8 code unchanged", {3'b0, fs_code_o}, 8'h05);
    chk("R8 ss unchanged", {7'b0, ss_en_o}, 8'h01);
    chk("R8 tri unchanged", {7'b0, tristate_o}, 8'h01);
    rd(3'd0, d); chk("R8 ctrl unchanged", d, 8'h5B);
    rd(3'd1, d); chk("R8 status unchanged", d, 8'h80);
    rd(3'd3, d); chk("R8 status unchanged", d, 8'h00);

    // second power-on with different straps and writes during the sequence
    por(5'b10110, 1'b1, 5'b01001, 1'b0, 1'b1);
    repeat (2) @(negedge clk_i);
    rd(3'd0, d); chk("R9 early write ignored", d, 8'h00);
    chk("R2 second capture", {3'b0, fs_code_o}, 8'h09);
    chk("R6 sel48", {7'b0, sel24_o}, 8'h00);
    chk("R9 ss off", {7'b0, ss_en_o}, 8'h00);
    for (int a = 1; a < 4; a++) begin
      rd(3'(a), d); chk("R7 status2", d, stat_exp(a, 5'b01001, 1'b0));
    end
    wr(3'd0, 8'h08); #1;
    chk("R4 zero sw code", {3'b0, fs_code_o}, 8'h00);
    wr(3'd0, 8'h00); #1;
    chk("R3 back to hw", {3'b0, fs_code_o}, 8'h09);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule